// File: doc/BRIEF.md
# Video Memory Read Prefetch Port

This block is a byte-wide CPU port onto a word-organised video memory. The CPU loads a word address one byte at a time, then fetches data through two read operations: one returns the low byte and one returns the high byte of a 16-bit prefetch latch. Reads never go to the memory directly. They take whatever the latch holds. The latch reloads from memory after every address load and on every read that advances the address. On an advancing read, the reload uses the address as it stood before the step.

A one-bit stepping mode chooses which byte access moves the address forward: the low-byte access or the high-byte access. Byte writes into the memory obey the same stepping rule, but they never disturb the prefetch latch. Because of this ordering, the first word after an address load comes back twice, and later reads follow increasing addresses. The memory model is a synchronous word RAM with byte write enables and one cycle of read latency. While a reload is in flight, the port lowers its ready output for exactly one cycle.

Top module: `vpp_top`

## Requirements
- R1: After reset, cpu_ready is 1, cpu_rdata is 0x00, the word address is 0, the prefetch latch holds 0x0000, and the stepping mode is 0 (low-byte access steps).
- R2: An access is taken on a rising edge where cpu_valid and cpu_ready are both 1. The cpu_op codes are: 0 address low load, 1 address high load, 2 read low, 3 read high, 4 write low, 5 write high, 6 mode set. Code 7 has no effect.
- R3: Op 0 loads address bits 7:0 from cpu_wdata. Op 1 loads address bits 14:8 from cpu_wdata bits 6:0. Either load makes the latch reload from the word at the new address, and cpu_ready is 0 for exactly the one cycle after the load.
- R4: Op 2 puts latch bits 7:0 on cpu_rdata, and op 3 puts latch bits 15:8 there. The byte is the latch value from before the access and appears in the cycle after the access. cpu_rdata holds until the next read.
- R5: Op 6 sets the stepping mode from cpu_wdata bit 0. With mode 0, ops 2 and 4 step the address. With mode 1, ops 3 and 5 step it.
- R6: A stepping read first returns the old latch byte, then reloads the latch from the unchanged address, then adds 1 to the address. cpu_ready is 0 for one cycle.
- R7: A read that does not step changes neither the address nor the latch.
- R8: Op 4 writes cpu_wdata into bits 7:0 of the addressed word, and op 5 writes it into bits 15:8. The address steps per R5, and the latch is left unchanged.
- R9: The 15-bit address wraps from 0x7FFF to 0. The memory is indexed by the low RAM_AW address bits, so higher addresses mirror it.
- R10: An access presented while cpu_ready is 0 is ignored.
- R11: After an address load, the first word is read back twice, and later reads follow increasing addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Access request |
| cpu_op | input | 3 | Access code (R2) |
| cpu_wdata | input | 8 | Address, data or mode byte |
| cpu_rdata | output | 8 | Last byte read from the latch |
| cpu_ready | output | 1 | High when an access can be taken |

## Verification
The bench uses ADDR_W of 15 and RAM_AW of 6, so the memory holds 64 words. With only 64 words, the bench can fill every word through the write path. Loading address 0x7FFF then reaches the mirrored top word, and stepping past it covers the wrap back to word 0. Both stepping modes are run on those contents, which covers the repeated first word, reads that do not step, and writes that step without touching the latch.

// File: rtl/vpp_pkg.sv
package vpp_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_ADDR_LO = 3'd0,
        OP_ADDR_HI = 3'd1,
        OP_RD_LO   = 3'd2,
        OP_RD_HI   = 3'd3,
        OP_WR_LO   = 3'd4,
        OP_WR_HI   = 3'd5,
        OP_MODE    = 3'd6,
        OP_NONE    = 3'd7
    } vpp_op_e;

endpackage

// File: rtl/vpp_word_ram.sv
module vpp_word_ram #(
    parameter int ADDR_W = 15,
    parameter int RAM_AW = 8
) (
    input  logic                      clk,
    input  logic [1:0]                we,
    input  logic [ADDR_W-1:0]         waddr,
    input  logic [vpp_pkg::BYTE_W-1:0] wbyte,
    input  logic                      re,
    input  logic [ADDR_W-1:0]         raddr,
    output logic [vpp_pkg::WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << RAM_AW;
    localparam int LANES = vpp_pkg::WORD_W / vpp_pkg::BYTE_W;

    logic [vpp_pkg::WORD_W-1:0] mem [DEPTH];
    logic [vpp_pkg::WORD_W-1:0] rdata_q;
    logic [RAM_AW-1:0]          widx;
    logic [RAM_AW-1:0]          ridx;

    // Upper address bits fold onto the array (mirroring)
    always_comb begin
        widx = RAM_AW'(waddr % ADDR_W'(DEPTH));
        ridx = RAM_AW'(raddr % ADDR_W'(DEPTH));
    end

    always_ff @(posedge clk) begin
        for (int g = 0; g < LANES; g++) begin
            if (we[g]) begin
                mem[widx][g*vpp_pkg::BYTE_W +: vpp_pkg::BYTE_W] <= wbyte;
            end
        end
        if (re) begin
            rdata_q <= mem[ridx];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/vpp_addr_unit.sv
module vpp_addr_unit #(
    parameter int ADDR_W = 15
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ld_lo,
    input  logic                       ld_hi,
    input  logic                       bump,
    input  logic [vpp_pkg::BYTE_W-1:0] lo_byte,
    input  logic [ADDR_W-9:0]          hi_bits,
    output logic [ADDR_W-1:0]          addr_q,
    output logic [ADDR_W-1:0]          addr_nxt
);
    localparam int LO_W = vpp_pkg::BYTE_W;

    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        addr_d = addr_q;
        if (ld_lo) begin
            addr_d[LO_W-1:0] = lo_byte;
        end
        if (ld_hi) begin
            addr_d[ADDR_W-1:LO_W] = hi_bits;
        end
        if (bump) begin
            addr_d = addr_q + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr_nxt = addr_d;

    assert_step_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bump |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

    assert_addr_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_lo && !ld_hi && !bump) |=> $stable(addr_q));

endmodule

// File: rtl/vpp_prefetch_latch.sv
module vpp_prefetch_latch (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [vpp_pkg::WORD_W-1:0] load_data,
    input  logic                       take,
    input  logic                       take_hi,
    output logic [vpp_pkg::WORD_W-1:0] word_q,
    output logic [vpp_pkg::BYTE_W-1:0] rdata_q
);
    typedef struct packed {
        logic [vpp_pkg::WORD_W-1:0] word;
        logic [vpp_pkg::BYTE_W-1:0] rdata;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.rdata = st_q.word[(take_hi ? vpp_pkg::BYTE_W : 0) +: vpp_pkg::BYTE_W];
        end
        if (load) begin
            st_d.word = load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_q  = st_q.word;
    assign rdata_q = st_q.rdata;

    assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(rdata_q));

endmodule

// File: rtl/vpp_top.sv
module vpp_top #(
    parameter int ADDR_W = 15,
    parameter int RAM_AW = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_valid,
    input  logic [2:0] cpu_op,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    output logic       cpu_ready
);
    import vpp_pkg::*;

    localparam int HI_W = ADDR_W - BYTE_W;

    typedef struct packed {
        logic mode;
        logic busy;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    vpp_op_e           op;
    logic              accept;
    logic              is_addr;
    logic              is_rd;
    logic              is_wr;
    logic              step_hit;
    logic              bump;
    logic              reload;
    logic [1:0]        we;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_nxt;
    logic [ADDR_W-1:0] fetch_addr;
    logic [WORD_W-1:0] ram_rdata;
    logic [WORD_W-1:0] latch_word;

    always_comb begin
        op       = vpp_op_e'(cpu_op);
        accept   = cpu_valid && !ctl_q.busy;
        is_addr  = accept && (op == OP_ADDR_LO || op == OP_ADDR_HI);
        is_rd    = accept && (op == OP_RD_LO || op == OP_RD_HI);
        is_wr    = accept && (op == OP_WR_LO || op == OP_WR_HI);
        // bit 0 of a data op picks the byte lane; it steps when it matches mode
        step_hit = (cpu_op[0] == ctl_q.mode);
        bump     = (is_rd || is_wr) && step_hit;
        reload   = is_addr || (is_rd && step_hit);
        we       = is_wr ? (cpu_op[0] ? 2'b10 : 2'b01) : 2'b00;
        // address load: fetch from new address; stepping read: from old one
        fetch_addr = is_addr ? addr_nxt : addr_q;

        ctl_d      = ctl_q;
        ctl_d.busy = reload;
        if (accept && op == OP_MODE) begin
            ctl_d.mode = cpu_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    vpp_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_lo    (accept && op == OP_ADDR_LO),
        .ld_hi    (accept && op == OP_ADDR_HI),
        .bump     (bump),
        .lo_byte  (cpu_wdata),
        .hi_bits  (cpu_wdata[HI_W-1:0]),
        .addr_q   (addr_q),
        .addr_nxt (addr_nxt)
    );

    vpp_word_ram #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW)) u_ram (
        .clk   (clk),
        .we    (we),
        .waddr (addr_q),
        .wbyte (cpu_wdata),
        .re    (reload),
        .raddr (fetch_addr),
        .rdata (ram_rdata)
    );

    vpp_prefetch_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ctl_q.busy),
        .load_data (ram_rdata),
        .take      (is_rd),
        .take_hi   (cpu_op[0]),
        .word_q    (latch_word),
        .rdata_q   (cpu_rdata)
    );

    assign cpu_ready = !ctl_q.busy;

    assert_ready_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ready |=> cpu_ready);

    assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && !cpu_ready) |=> ($stable(addr_q) && $stable(cpu_rdata)));

    assert_write_keeps_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr |=> $stable(latch_word));

    assert_still_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && !step_hit) |=> ($stable(latch_word) && $stable(addr_q)));

    assert_step_read_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && step_hit) |=> !cpu_ready);

endmodule

// File: tb/tb_vpp_top.sv
module tb_vpp_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 15;
    localparam int RAM_AW = 6;

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] d;
        logic       chk;
        logic [7:0] exp;
    } vec_t;

    // memory filled as word i = {0x40+i, i}
    localparam int NV = 34;
    localparam vec_t TBL [NV] = '{
        '{3'd6, 8'h00, 1'b0, 8'h00},   // mode 0: low access steps (R5)
        '{3'd0, 8'h05, 1'b0, 8'h00},
        '{3'd1, 8'h00, 1'b0, 8'h00},   // address 5 (R3)
        '{3'd2, 8'h00, 1'b1, 8'h05},   // R11 first copy
        '{3'd3, 8'h00, 1'b1, 8'h45},
        '{3'd2, 8'h00, 1'b1, 8'h05},   // R11 repeat
        '{3'd3, 8'h00, 1'b1, 8'h46},
        '{3'd2, 8'h00, 1'b1, 8'h06},
        '{3'd3, 8'h00, 1'b1, 8'h47},
        '{3'd6, 8'h01, 1'b0, 8'h00},   // mode 1 (R5)
        '{3'd0, 8'h10, 1'b0, 8'h00},
        '{3'd3, 8'h00, 1'b1, 8'h50},   // R6
        '{3'd2, 8'h00, 1'b1, 8'h10},
        '{3'd3, 8'h00, 1'b1, 8'h50},
        '{3'd2, 8'h00, 1'b1, 8'h11},
        '{3'd2, 8'h00, 1'b1, 8'h11},   // R7
        '{3'd3, 8'h00, 1'b1, 8'h51},
        '{3'd2, 8'h00, 1'b1, 8'h12},
        '{3'd4, 8'hEE, 1'b0, 8'h00},   // R8 write low, no step
        '{3'd5, 8'hDD, 1'b0, 8'h00},   // R8 write high, steps
        '{3'd2, 8'h00, 1'b1, 8'h12},   // R8 latch untouched
        '{3'd3, 8'h00, 1'b1, 8'h52},
        '{3'd2, 8'h00, 1'b1, 8'h14},
        '{3'd0, 8'h13, 1'b0, 8'h00},
        '{3'd2, 8'h00, 1'b1, 8'hEE},   // R8 bytes landed
        '{3'd3, 8'h00, 1'b1, 8'hDD},
        '{3'd0, 8'hFF, 1'b0, 8'h00},
        '{3'd1, 8'h7F, 1'b0, 8'h00},   // 0x7FFF mirrors word 63 (R9)
        '{3'd3, 8'h00, 1'b1, 8'h7F},
        '{3'd2, 8'h00, 1'b1, 8'h3F},
        '{3'd3, 8'h00, 1'b1, 8'h7F},
        '{3'd2, 8'h00, 1'b1, 8'h00},   // R9 wrapped to word 0
        '{3'd3, 8'h00, 1'b1, 8'h40},
        '{3'd2, 8'h00, 1'b1, 8'h01}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_valid = 1'b0;
    logic [2:0] cpu_op = 3'd7;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       cpu_ready;

    int checks = 0;
    int errors = 0;

    vpp_top #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_valid (cpu_valid),
        .cpu_op    (cpu_op),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .cpu_ready (cpu_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [2:0] op, input logic [7:0] d);
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_valid = 1'b1;
        cpu_op    = op;
        cpu_wdata = d;
        @(negedge clk);
        cpu_valid = 1'b0;
        cpu_op    = 3'd7;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready", {7'd0, cpu_ready}, 8'h01);
        check("R1 rdata", cpu_rdata, 8'h00);
        access(3'd3, 8'h00);          // mode 0: high read does not step
        check("R1 latch zero", cpu_rdata, 8'h00);

        // fill the memory through the write path, mode 1
        access(3'd6, 8'h01);
        access(3'd0, 8'h00);
        access(3'd1, 8'h00);
        for (int i = 0; i < 64; i++) begin
            access(3'd4, 8'(i));
            access(3'd5, 8'(8'h40 + i));
        end

        for (int i = 0; i < NV; i++) begin
            access(TBL[i].op, TBL[i].d);
            if (TBL[i].chk) begin
                check($sformatf("R4 vector %0d", i), cpu_rdata, TBL[i].exp);
            end
        end

        // R3 / R10: ready low after address load; access during it ignored
        access(3'd0, 8'h08);
        access(3'd1, 8'h00);
        check("R3 ready low", {7'd0, cpu_ready}, 8'h00);
        cpu_valid = 1'b1;
        cpu_op    = 3'd3;
        @(negedge clk);
        cpu_valid = 1'b0;
        cpu_op    = 3'd7;
        check("R10 rdata kept", cpu_rdata, 8'h01);
        access(3'd2, 8'h00);
        check("R10 no step", cpu_rdata, 8'h08);
        access(3'd3, 8'h00);
        check("R6 ready low", {7'd0, cpu_ready}, 8'h00);
        check("R6 old byte", cpu_rdata, 8'h48);
        access(3'd3, 8'h00);
        check("R11 repeat", cpu_rdata, 8'h48);
        access(3'd7, 8'hFF);          // R2 code 7 ignored
        access(3'd2, 8'h00);
        check("R2 code 7", cpu_rdata, 8'h09);

        // R8 in mode 0: low write steps, latch left alone
        access(3'd6, 8'h00);
        access(3'd0, 8'h20);
        access(3'd4, 8'hAB);
        access(3'd5, 8'hCD);
        access(3'd2, 8'h00);
        check("R8 latch kept", cpu_rdata, 8'h20);
        access(3'd3, 8'h00);
        check("R8 high lane", cpu_rdata, 8'hCD);
        access(3'd0, 8'h20);
        access(3'd2, 8'h00);
        check("R8 low lane", cpu_rdata, 8'hAB);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule